// File: doc/BRIEF.md
# Lane-wise byte align-right unit

This datapath joins two packed operands into a double-width value and shifts it right by a whole number of bytes. It returns the low-order half of that value as the result. The byte count comes from an 8-bit immediate. In the wider widths the joining and shifting happen separately inside every 16-byte lane. One immediate serves all lanes, so a 256-bit or 512-bit request yields two or four independent 16-byte results. A narrow 64-bit width joins two 8-byte operands and returns 8 bytes.

A per-byte write mask may be applied to the computed bytes. A cleared mask bit either forces its byte to zero or keeps the byte from a separate previous-destination input, depending on a zeroing control. When masking is off, every byte of the active width is written. The result is registered, so it appears one clock after the inputs are sampled. The unit has separate ports for the upper source, the lower source and the previous destination. A two-operand usage, where the destination is also the upper source, is obtained by feeding the same vector to both `src_hi` and `old_dst`. Decode, memory access and fault handling are outside this block.

Top module: `byte_align_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes all zero at that edge.
- R2: `result` reflects the inputs sampled at the previous rising edge and holds steady between edges.
- R3: Within a lane, `src_hi` forms the upper half and `src_lo` the lower half of the joined value, which is shifted right by `imm` bytes; the low bytes are the result. For example, `imm`=0 gives the `src_lo` lane and `imm`=16 gives the `src_hi` lane in the wide widths.
- R4: With `width_sel`=0 (64-bit), bytes 0..7 of each operand form a 16-byte joined value, result bytes 0..7 are produced, and result bytes 8..63 are zero.
- R5: With `width_sel`=1 (128-bit), lane 0 (bytes 0..15) forms a 32-byte joined value, and result bytes 16..63 are zero.
- R6: With `width_sel`=2 (256-bit) or 3 (512-bit), lanes 0..1 or 0..3 are each processed on their own with the same `imm`. In the 256-bit width, result bytes 32..63 are zero.
- R7: Byte positions shifted in from beyond the top of the joined value are zero. An `imm` of 32 or more (16 or more in the 64-bit width) gives all-zero active bytes when masking is off.
- R8: With `mask_en`=1, bit i of `byte_mask` governs active result byte i. A set bit writes the computed byte. For a cleared bit, `zero_mode`=1 gives zero and `zero_mode`=0 gives byte i of `old_dst`. Bytes outside the active width stay zero.
- R9: With `mask_en`=0, `byte_mask` and `zero_mode` have no effect and every active byte takes its computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 2 | 0: 64-bit, 1: 128-bit, 2: 256-bit, 3: 512-bit |
| imm | input | 8 | Right shift amount in bytes |
| src_hi | input | 512 | First operand, upper half of each joined lane |
| src_lo | input | 512 | Second operand, lower half of each joined lane |
| old_dst | input | 512 | Previous destination value for merge masking |
| byte_mask | input | 64 | Per-byte write mask, bit i for byte i |
| mask_en | input | 1 | 1: apply the write mask, 0: write all active bytes |
| zero_mode | input | 1 | 1: masked-off bytes become zero, 0: they keep `old_dst` |
| result | output | 512 | Registered result vector |

## Verification
The output register has no state beyond the last result, so any wrong internal value is visible at `result` at the first edge after the offending inputs, and at no later edge. Swapped operand halves, a wrong byte shift, or a lane that leaks into its neighbour each show up as misplaced bytes. The operands carry distinct byte values, so the position of such a byte identifies the fault. A stale width decode leaves nonzero bytes above the active width, and a mask fault shows `old_dst` bytes where zeros belong, or the reverse. Sweeping all 256 immediates in each width puts every shift boundary, including the zero-fill edge, at the ports.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [1:0] {
    WID_64  = 2'd0,
    WID_128 = 2'd1,
    WID_256 = 2'd2,
    WID_512 = 2'd3
  } wid_e;
endpackage

// File: rtl/lane_shift.sv
module lane_shift #(
  parameter int LB = 16
) (
  input  logic            narrow,
  input  logic [7:0]      imm,
  input  logic [LB*8-1:0] hi,
  input  logic [LB*8-1:0] lo,
  output logic [LB*8-1:0] res
);
  localparam int CW = 2 * LB * 8;
  localparam int HW = (LB / 2) * 8;

  logic [CW-1:0] joined;
  logic [CW-1:0] moved;

  always_comb begin
    joined = '0;
    if (narrow) joined[2*HW-1:0] = {hi[HW-1:0], lo[HW-1:0]};
    else        joined = {hi, lo};
    // shift past the top leaves zeros
    moved = joined >> {imm, 3'b000};
  end

  assign res = moved[LB*8-1:0];
endmodule

// File: rtl/byte_select.sv
module byte_select #(
  parameter int NB = 64
) (
  input  logic [NB-1:0]   active,
  input  logic            mask_en,
  input  logic            zero_mode,
  input  logic [NB-1:0]   byte_mask,
  input  logic [NB*8-1:0] calc,
  input  logic [NB*8-1:0] old_dst,
  output logic [NB*8-1:0] out
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic take_new;
    assign take_new = !mask_en || byte_mask[b];
    always_comb begin
      if (!active[b])     out[b*8 +: 8] = 8'h00;
      else if (take_new)  out[b*8 +: 8] = calc[b*8 +: 8];
      else if (zero_mode) out[b*8 +: 8] = 8'h00;
      else                out[b*8 +: 8] = old_dst[b*8 +: 8];
    end
  end
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit #(
  parameter int LANE_BYTES = 16,
  parameter int NUM_LANES  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [1:0]                       width_sel,
  input  logic [7:0]                       imm,
  input  logic [LANE_BYTES*NUM_LANES*8-1:0] src_hi,
  input  logic [LANE_BYTES*NUM_LANES*8-1:0] src_lo,
  input  logic [LANE_BYTES*NUM_LANES*8-1:0] old_dst,
  input  logic [LANE_BYTES*NUM_LANES-1:0]   byte_mask,
  input  logic                             mask_en,
  input  logic                             zero_mode,
  output logic [LANE_BYTES*NUM_LANES*8-1:0] result
);
  import align_pkg::*;

  localparam int NB     = LANE_BYTES * NUM_LANES;
  localparam int LW     = LANE_BYTES * 8;
  localparam int MIN_NB = LANE_BYTES / 2;

  wid_e          wid;
  logic [NB-1:0] active;
  logic [NB*8-1:0] calc;
  logic [NB*8-1:0] picked;

  assign wid = wid_e'(width_sel);

  // active byte count doubles with each width step
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      active[b] = (b < (MIN_NB << width_sel));
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic narrow_l;
    assign narrow_l = (l == 0) && (wid == WID_64);
    lane_shift #(.LB(LANE_BYTES)) u_shift (
      .narrow (narrow_l),
      .imm    (imm),
      .hi     (src_hi[l*LW +: LW]),
      .lo     (src_lo[l*LW +: LW]),
      .res    (calc[l*LW +: LW])
    );
  end

  byte_select #(.NB(NB)) u_sel (
    .active    (active),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .byte_mask (byte_mask),
    .calc      (calc),
    .old_dst   (old_dst),
    .out       (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= picked;
  end
endmodule

// File: rtl/align_chk.sv
module align_chk #(
  parameter int NB = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      width_sel,
  input logic [7:0]      imm,
  input logic [NB*8-1:0] src_hi,
  input logic [NB*8-1:0] src_lo,
  input logic [NB*8-1:0] old_dst,
  input logic [NB-1:0]   byte_mask,
  input logic            mask_en,
  input logic            zero_mode,
  input logic [NB*8-1:0] result
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> result == '0);

  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    width_sel == 2'd0 |=> result[NB*8-1:64] == '0);

  // R3
  zero_shift_low_chk: assert property (@(posedge clk) disable iff (rst)
    (width_sel == 2'd3 && imm == 8'd0 && !mask_en) |=> result == $past(src_lo));

  // R3
  lane_shift_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (width_sel == 2'd1 && imm == 8'd16 && !mask_en) |=> result[127:0] == $past(src_hi[127:0]));

  // R7
  far_shift_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (width_sel != 2'd0 && imm >= 8'd32 && !mask_en) |=> result == '0);

  // R8
  zero_all_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_en && zero_mode && byte_mask == '0) |=> result == '0);

  // R8
  merge_all_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_en && !zero_mode && byte_mask == '0 && width_sel == 2'd3) |=> result == $past(old_dst));
endmodule

bind byte_align_unit align_chk #(.NB(LANE_BYTES*NUM_LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .width_sel (width_sel),
  .imm       (imm),
  .src_hi    (src_hi),
  .src_lo    (src_lo),
  .old_dst   (old_dst),
  .byte_mask (byte_mask),
  .mask_en   (mask_en),
  .zero_mode (zero_mode),
  .result    (result)
);

// File: tb/sim_byte_align_unit.sv
module sim_byte_align_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      width_sel = '0;
  logic [7:0]      imm = '0;
  logic [NB*8-1:0] src_hi = '0, src_lo = '0, old_dst = '0;
  logic [NB-1:0]   byte_mask = '0;
  logic            mask_en = 1'b0, zero_mode = 1'b0;
  logic [NB*8-1:0] result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_align_unit u0 (
    .clk(clk), .rst(rst), .width_sel(width_sel), .imm(imm),
    .src_hi(src_hi), .src_lo(src_lo), .old_dst(old_dst),
    .byte_mask(byte_mask), .mask_en(mask_en), .zero_mode(zero_mode),
    .result(result)
  );

  // stimulus table: {width_sel[1:0], imm[7:0], mask_en, zero_mode}
  localparam logic [11:0] TBL [0:11] = '{
    {2'd0, 8'd3,  1'b0, 1'b0},
    {2'd0, 8'd8,  1'b1, 1'b1},
    {2'd1, 8'd5,  1'b1, 1'b0},
    {2'd1, 8'd31, 1'b0, 1'b0},
    {2'd2, 8'd17, 1'b1, 1'b1},
    {2'd2, 8'd0,  1'b1, 1'b0},
    {2'd3, 8'd9,  1'b0, 1'b0},
    {2'd3, 8'd16, 1'b1, 1'b0},
    {2'd3, 8'd24, 1'b1, 1'b1},
    {2'd3, 8'd40, 1'b1, 1'b0},
    {2'd2, 8'd255,1'b0, 1'b0},
    {2'd0, 8'd15, 1'b1, 1'b0}
  };

  function automatic logic [NB*8-1:0] model(
    input logic [1:0] w, input logic [7:0] sh,
    input logic [NB*8-1:0] h, input logic [NB*8-1:0] l, input logic [NB*8-1:0] od,
    input logic [NB-1:0] m, input logic me, input logic zm);
    logic [NB*8-1:0] r;
    r = '0;
    for (int i = 0; i < NB; i++) begin
      int lane, pos, k, half;
      logic [7:0] v;
      if (i >= (8 << w)) continue;
      half = (w == 2'd0) ? 8 : 16;
      lane = i / 16;
      pos  = i % 16;
      k    = pos + int'(sh);
      if (k < half)          v = l[(lane*16 + k)*8 +: 8];
      else if (k < 2*half)   v = h[(lane*16 + k - half)*8 +: 8];
      else                   v = 8'h00;
      if (me && !m[i]) v = zm ? 8'h00 : od[i*8 +: 8];
      r[i*8 +: 8] = v;
    end
    return r;
  endfunction

  function automatic logic [NB*8-1:0] rnd_vec();
    logic [NB*8-1:0] v;
    for (int j = 0; j < NB/4; j++) v[j*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [NB*8-1:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s w=%0d imm=%0d act=%h exp=%h", tag, width_sel, imm, result, exp);
    end
  endtask

  task automatic drive(input logic [1:0] w, input logic [7:0] sh, input logic me, input logic zm);
    @(negedge clk);
    width_sel = w; imm = sh; mask_en = me; zero_mode = zm;
    src_hi = rnd_vec(); src_lo = rnd_vec(); old_dst = rnd_vec();
    byte_mask = {$urandom, $urandom};
    @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic [1:0] w, input logic [7:0] sh, input logic me);
    if (me) return "R8";
    if ((w == 2'd0 && sh >= 8'd16) || sh >= 8'd32) return "R7";
    if (w == 2'd0) return "R4";
    if (w == 2'd1) return "R5";
    return "R6";
  endfunction

  initial begin
    fork
      begin
        // R1: reset with busy inputs
        src_hi = rnd_vec(); src_lo = rnd_vec(); old_dst = rnd_vec();
        width_sel = 2'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int t = 0; t < 12; t++) begin
          drive(TBL[t][11:10], TBL[t][9:2], TBL[t][1], TBL[t][0]);
          check(tag_of(width_sel, imm, mask_en),
                model(width_sel, imm, src_hi, src_lo, old_dst, byte_mask, mask_en, zero_mode));
        end

        // full sweep of every immediate in every width (R3..R7)
        for (int w = 0; w < 4; w++) begin
          for (int s = 0; s < 256; s++) begin
            drive(w[1:0], s[7:0], 1'b0, 1'b0);
            check(tag_of(width_sel, imm, 1'b0),
                  model(width_sel, imm, src_hi, src_lo, old_dst, byte_mask, 1'b0, 1'b0));
          end
        end

        // R3: imm 0 and 16 pick whole operands per lane
        drive(2'd3, 8'd0, 1'b0, 1'b0);
        check("R3", src_lo);
        drive(2'd3, 8'd16, 1'b0, 1'b0);
        check("R3", src_hi);

        // R9: mask all clear, zeroing on, masking off -> unmasked value
        drive(2'd3, 8'd7, 1'b0, 1'b1);
        byte_mask = '0;
        @(negedge clk);
        @(posedge clk); #1;
        check("R9", model(2'd3, 8'd7, src_hi, src_lo, old_dst, '1, 1'b1, 1'b1));

        // R8: merge keeps old_dst fully, zeroing clears fully
        drive(2'd3, 8'd5, 1'b1, 1'b0);
        byte_mask = '0;
        @(posedge clk); #1;
        check("R8", old_dst);
        @(negedge clk); zero_mode = 1'b1;
        @(posedge clk); #1;
        check("R8", '0);

        // R2: output holds until the next edge
        drive(2'd1, 8'd4, 1'b0, 1'b0);
        begin
          logic [NB*8-1:0] prev;
          prev = model(2'd1, 8'd4, src_hi, src_lo, old_dst, byte_mask, 1'b0, 1'b0);
          check("R2", prev);
          @(negedge clk);
          imm = 8'd9; src_lo = rnd_vec();
          #1;
          check("R2", prev);
          @(posedge clk); #1;
          check("R2", model(2'd1, 8'd9, src_hi, src_lo, old_dst, byte_mask, 1'b0, 1'b0));
        end

        // R1: reset mid-run clears
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", '0);
        @(negedge clk); rst = 1'b0;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule